// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes interrupt input lines to destination-addressed interrupt messages. Software reaches every internal register through two bus offsets: an index register chooses one internal register, and a data window reads or writes it. The internal space holds an identification register, a read-only version register, an arbitration register and a table of redirection entries. Each entry is a 64-bit value kept as a low word and a high word.

A rising edge on an input line looks up that line's entry. If the entry is unmasked, the line becomes pending. Pending lines leave one at a time as 64-bit message words on a valid/ready stream, lowest line number first. A message is offered by raising `msg_valid` and is consumed on a clock edge where `msg_ready` is high. While `msg_ready` is low the offered word and source ID hold steady, and new rising lines wait as pending.

Bus requests take one cycle. The response (`bus_rsp`, `bus_rdata`, `bus_err`) appears on the clock edge after the request.

Top module: `irq_route_ctrl`

## Requirements
- R1: Offset 0x00 is an 8-bit index register, readable (zero-extended to 32 bits) and writable. Every request at offset 0x00 or 0x10 is answered one cycle later with `bus_rsp`=1 and `bus_rdata` (0 for writes).
- R2: Offset 0x10 is the window onto the register selected by the index. Index 0x00 is the ID register, whose 4-bit field is bits 27:24 and resets to `cfg_id`. Index 0x02 is the arbitration register, whose 4-bit field is bits 27:24 and resets to 0. Both fields are writable, and all other bits read 0.
- R3: Index 0x01 reads 0x00170011 (version 0x11, highest entry number 0x17 with 24 entries). A write to it returns `bus_err`=1 and does not change the value.
- R4: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. After reset every low word reads 0x00010000 (mask bit 16 set) and every high word reads 0.
- R5: A window write to a low word updates every bit except bit 12 (delivery status) and bit 14 (remote IRR), which keep their value. A write to a high word replaces all 32 bits.
- R6: A request to an offset other than 0x00/0x10, or a window access whose index selects no implemented register, returns `bus_err`=1 and reads 0. Such a write changes no register.
- R7: A rising edge on line n below 24 whose entry has mask=0 yields exactly one message. If the entry has mask=1, no message is produced.
- R8: The message word carries the entry's bits 11:0 in bits 11:0 (vector 7:0, delivery mode 10:8, destination mode 11). It has level=1 in bit 14, the entry's trigger mode in bit 15, and the destination (entry bits 63:56) in bits 63:56. All other bits are 0. `msg_src` carries the ID field.
- R9: A rising edge on a line numbered 24 or above pulses `irq_range_err` for exactly one cycle, in the cycle after the edge, and produces no message.
- R10: Lines that rise in the same cycle are sent lowest number first, one per accepted transfer. The others wait as pending.
- R11: While `msg_valid`=1 and `msg_ready`=0, `msg_valid`, `msg_word` and `msg_src` hold steady.
- R12: A message appears on `msg_valid` on the clock edge that samples the rising line, provided the output is free. After reset `msg_valid`, `irq_range_err`, `bus_rsp` and `bus_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_id | input | 4 | Reset value of the ID field |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | Request is a write |
| bus_addr | input | 8 | Byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rsp | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Request rejected |
| irq_in | input | 32 | Interrupt input lines |
| irq_range_err | output | 1 | A line beyond the table rose |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_word | output | 64 | Message word |
| msg_src | output | 4 | Source ID of the message |

## Verification
The assertions assume that `irq_in` changes synchronously to `clk`. They also assume that `bus_req` is a single-cycle strobe with stable address and data, and that the consumer raises `msg_ready` eventually. The bench drives every input on the falling edge and pulses each line high for exactly one cycle before lowering it. Randomly programmed entries are fired one line at a time with `msg_ready` high, so the expected output is known exactly. Only the directed cases raise several lines together or hold `msg_ready` low.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TBL    = 8'h10;
  localparam logic [7:0] VER_CODE   = 8'h11;
  localparam logic [31:0] LO_HW_BITS = 32'h0000_5000;
  localparam logic [31:0] LO_RESET   = 32'h0001_0000;

  typedef struct packed {
    logic [7:0]  dest;
    logic [35:0] zero_hi;
    logic [1:0]  shorthand;
    logic [1:0]  rrd_stat;
    logic        trig;
    logic        level;
    logic        rsv13;
    logic        status;
    logic        dst_logical;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } msg_word_t;

  function automatic logic [63:0] form_msg(input logic [63:0] ent);
    msg_word_t m;
    m = '0;
    m.vector      = ent[7:0];
    m.mode        = ent[10:8];
    m.dst_logical = ent[11];
    m.level       = 1'b1;
    m.trig        = ent[15];
    m.dest        = ent[63:56];
    return m;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned ENTRIES = 24,
  parameter int unsigned ENT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cfg_id,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               bus_rsp,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  output logic [3:0]         id_o,
  output logic [ENTRIES-1:0] mask_o,
  input  logic [ENT_W-1:0]   sel_i,
  output logic [63:0]        entry_o
);
  localparam logic [7:0] MAX_IDX  = 8'(ENTRIES - 1);
  localparam logic [7:0] TBL_SPAN = 8'(2 * ENTRIES);
  localparam logic [31:0] VER_WORD = {8'h00, MAX_IDX, 8'h00, VER_CODE};

  logic [7:0]  idx_q;
  logic [3:0]  id_q, arb_q;
  logic [31:0] lo_q [ENTRIES];
  logic [31:0] hi_q [ENTRIES];
  logic [2*ENTRIES-1:0] hw_bits;

  logic [7:0] rel, rel_half;
  logic [ENT_W-1:0] ent_n;
  logic in_tbl;
  assign rel      = idx_q - IDX_TBL;
  assign rel_half = rel >> 1;
  assign ent_n    = rel_half[ENT_W-1:0];
  assign in_tbl   = (idx_q >= IDX_TBL) && (rel < TBL_SPAN);

  logic [31:0] rd_val;
  logic err_c, idx_wr, id_wr, arb_wr, tbl_wr;

  always_comb begin
    rd_val = '0;
    err_c  = 1'b0;
    idx_wr = 1'b0;
    id_wr  = 1'b0;
    arb_wr = 1'b0;
    tbl_wr = 1'b0;
    if (bus_req) begin
      case (bus_addr)
        OFS_INDEX: begin
          rd_val = {24'h0, idx_q};
          idx_wr = bus_we;
        end
        OFS_WINDOW: begin
          if (idx_q == IDX_ID) begin
            rd_val = {4'h0, id_q, 24'h0};
            id_wr  = bus_we;
          end else if (idx_q == IDX_VER) begin
            rd_val = VER_WORD;
            err_c  = bus_we;
          end else if (idx_q == IDX_ARB) begin
            rd_val = {4'h0, arb_q, 24'h0};
            arb_wr = bus_we;
          end else if (in_tbl) begin
            rd_val = idx_q[0] ? hi_q[ent_n] : lo_q[ent_n];
            tbl_wr = bus_we;
          end else begin
            err_c = 1'b1;
          end
        end
        default: err_c = 1'b1;
      endcase
    end
    if (err_c) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      id_q      <= cfg_id;
      arb_q     <= '0;
      bus_rsp   <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rsp   <= bus_req;
      bus_rdata <= bus_we ? 32'h0 : rd_val;
      bus_err   <= err_c;
      if (idx_wr) idx_q <= bus_wdata[7:0];
      if (id_wr)  id_q  <= bus_wdata[27:24];
      if (arb_wr) arb_q <= bus_wdata[27:24];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here = tbl_wr && (rel_half == 8'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= LO_RESET;
        hi_q[g] <= '0;
      end else if (wr_here) begin
        if (idx_q[0]) hi_q[g] <= bus_wdata;
        else          lo_q[g] <= (bus_wdata & ~LO_HW_BITS) | (lo_q[g] & LO_HW_BITS);
      end
    end
    assign mask_o[g] = lo_q[g][16];
    assign hw_bits[2*g+1:2*g] = {lo_q[g][14], lo_q[g][12]};
  end

  assign id_o    = id_q;
  assign entry_o = {hi_q[sel_i], lo_q[sel_i]};

  // R5: hardware-owned status bits never move on a bus write
  p_hw_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> $stable(hw_bits));
  // R3: version writes are rejected
  p_ver_write_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == OFS_WINDOW && idx_q == IDX_VER) |=> (bus_err && bus_rsp));
  // R1: every request gets a response next cycle
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rsp);
endmodule

// File: rtl/irq_route_pend.sv
module irq_route_pend #(
  parameter int unsigned IN_LINES = 32,
  parameter int unsigned ENTRIES  = 24,
  parameter int unsigned ENT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IN_LINES-1:0] irq_in,
  input  logic [ENTRIES-1:0]  mask_i,
  input  logic                slot_free_i,
  output logic                grant_vld_o,
  output logic [ENT_W-1:0]    grant_idx_o,
  output logic                range_err_o
);
  logic [IN_LINES-1:0] irq_q, rise;
  logic [ENTRIES-1:0]  hits, pend_q, pend_all, grant_oh;

  assign rise     = irq_in & ~irq_q;
  assign hits     = rise[ENTRIES-1:0] & ~mask_i;
  assign pend_all = pend_q | hits;

  always_comb begin
    grant_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (pend_all[i]) grant_idx_o = ENT_W'(i);
    end
  end
  assign grant_vld_o = |pend_all;
  assign grant_oh    = grant_vld_o ? (ENTRIES'(1) << grant_idx_o) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= (slot_free_i && grant_vld_o) ? (pend_all & ~grant_oh) : pend_all;
    end
  end

  if (IN_LINES > ENTRIES) begin : g_range
    logic range_q;
    always_ff @(posedge clk) begin
      if (!rst_n) range_q <= 1'b0;
      else        range_q <= |rise[IN_LINES-1:ENTRIES];
    end
    assign range_err_o = range_q;
    // R9: flag only after an out-of-range line was high
    p_range_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      range_err_o |-> $past(|irq_in[IN_LINES-1:ENTRIES]));
  end else begin : g_norange
    assign range_err_o = 1'b0;
  end

  // R10: each accepted transfer retires exactly one pending line
  p_pend_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free_i && pend_q != '0 && hits == '0) |=>
      ($countones(pend_q) == $past($countones(pend_q)) - 1));
endmodule

// File: rtl/irq_route_out.sv
module irq_route_out
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        grant_vld_i,
  input  logic [63:0] entry_i,
  input  logic [3:0]  id_i,
  output logic        slot_free_o,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_word,
  output logic [3:0]  msg_src
);
  assign slot_free_o = !msg_valid || msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_word  <= '0;
      msg_src   <= '0;
    end else if (slot_free_o) begin
      msg_valid <= grant_vld_i;
      if (grant_vld_i) begin
        msg_word <= form_msg(entry_i);
        msg_src  <= id_i;
      end
    end
  end

  // R11: offered message holds under back-pressure
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_word) && $stable(msg_src)));
  // R8: level bit set on every offered message
  p_level_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_word[14] && msg_word[17:16] == 2'b00));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int unsigned IN_LINES = 32,
  parameter int unsigned ENTRIES  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          cfg_id,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                bus_rsp,
  output logic [31:0]         bus_rdata,
  output logic                bus_err,
  input  logic [IN_LINES-1:0] irq_in,
  output logic                irq_range_err,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [63:0]         msg_word,
  output logic [3:0]          msg_src
);
  localparam int unsigned ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [3:0]         id_w;
  logic [ENTRIES-1:0] mask_w;
  logic [ENT_W-1:0]   grant_idx_w;
  logic               grant_vld_w, slot_free_w;
  logic [63:0]        entry_w;

  irq_route_regs #(.ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rsp(bus_rsp), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .id_o(id_w), .mask_o(mask_w), .sel_i(grant_idx_w), .entry_o(entry_w)
  );

  irq_route_pend #(.IN_LINES(IN_LINES), .ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_i(mask_w),
    .slot_free_i(slot_free_w), .grant_vld_o(grant_vld_w),
    .grant_idx_o(grant_idx_w), .range_err_o(irq_range_err)
  );

  irq_route_out u_out (
    .clk(clk), .rst_n(rst_n), .grant_vld_i(grant_vld_w), .entry_i(entry_w),
    .id_i(id_w), .slot_free_o(slot_free_w), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_word(msg_word), .msg_src(msg_src)
  );
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_id = 4'h5;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rsp, bus_err, irq_range_err, msg_valid;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic msg_ready = 1'b1;
  logic [63:0] msg_word;
  logic [3:0] msg_src;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctrl u_irq_route_ctrl (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_msg(input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] m = '0;
    m[11:0] = lo[11:0];
    m[14] = 1'b1;
    m[15] = lo[15];
    m[63:56] = hi[31:24];
    return m;
  endfunction

  task automatic xfer(input bit we, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
    check("R1 rsp", {63'h0, bus_rsp}, 64'h1);
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d, output logic er);
    logic [31:0] rd;
    xfer(1, 8'h00, {24'h0, idx}, rd, er);
    xfer(1, 8'h10, d, rd, er);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] rd, output logic er);
    xfer(1, 8'h00, {24'h0, idx}, rd, er);
    xfer(0, 8'h10, 32'h0, rd, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    logic [63:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 valid", {63'h0, msg_valid}, 64'h0);
    check("R12 range", {63'h0, irq_range_err}, 64'h0);
    check("R12 rsp", {62'h0, bus_rsp, bus_err}, 64'h0);
    // R1 index
    xfer(1, 8'h00, 32'h0000_0037, rd, er);
    xfer(0, 8'h00, 32'h0, rd, er);
    check("R1 index", {32'h0, rd}, 64'h37);
    // R3 version
    win_rd(8'h01, rd, er);
    check("R3 ver", {32'h0, rd}, 64'h0017_0011);
    win_wr(8'h01, 32'hFFFF_FFFF, er);
    check("R3 err", {63'h0, er}, 64'h1);
    win_rd(8'h01, rd, er);
    check("R3 kept", {32'h0, rd}, 64'h0017_0011);
    // R2 ID / arb
    win_rd(8'h00, rd, er);
    check("R2 id reset", {32'h0, rd}, 64'h0500_0000);
    win_rd(8'h02, rd, er);
    check("R2 arb reset", {32'h0, rd}, 64'h0);
    win_wr(8'h02, 32'hF3FF_FFFF, er);
    win_rd(8'h02, rd, er);
    check("R2 arb wr", {32'h0, rd}, 64'h0300_0000);
    win_wr(8'h00, 32'h1A12_3456, er);
    win_rd(8'h00, rd, er);
    check("R2 id wr", {32'h0, rd}, 64'h0A00_0000);
    // R4 reset entries
    win_rd(8'h10, rd, er);
    check("R4 lo0", {32'h0, rd}, 64'h0001_0000);
    win_rd(8'h3F, rd, er);
    check("R4 hi23", {32'h0, rd}, 64'h0);
    // R6 unimplemented
    win_wr(8'h05, 32'h1234_5678, er);
    check("R6 wr err", {63'h0, er}, 64'h1);
    win_rd(8'h05, rd, er);
    check("R6 rd zero", {31'h0, er, rd}, 64'h1_0000_0000);
    win_rd(8'h40, rd, er);
    check("R6 past table", {31'h0, er, rd}, 64'h1_0000_0000);
    xfer(1, 8'h08, 32'hFFFF_FFFF, rd, er);
    check("R6 bad ofs", {63'h0, er}, 64'h1);
    win_rd(8'h3E, rd, er);
    check("R6 no side effect", {32'h0, rd}, 64'h0001_0000);
    // R7 masked entry 2
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk); irq_in[2] = 1'b0;
    check("R7 masked", {63'h0, msg_valid}, 64'h0);
    @(negedge clk);
    check("R7 masked2", {63'h0, msg_valid}, 64'h0);
    // R9 range
    @(negedge clk); irq_in[27] = 1'b1;
    @(negedge clk); irq_in[27] = 1'b0;
    check("R9 flag", {62'h0, irq_range_err, msg_valid}, 64'h2);
    @(negedge clk);
    check("R9 pulse", {63'h0, irq_range_err}, 64'h0);
    // random entries R5 R7 R8 R12
    for (int k = 0; k < 40; k++) begin
      int n;
      logic [31:0] lo, hi;
      logic [7:0] base;
      n = int'($urandom % 24);
      lo = $urandom;
      hi = $urandom;
      if (k % 3 == 0) lo[16] = 1'b1;
      base = 8'(8'h10 + 2 * n);
      win_wr(base, lo, er);
      win_wr(base + 8'h1, hi, er);
      win_rd(base, rd, er);
      check("R5 lo keep 12/14", {32'h0, rd}, {32'h0, lo & ~32'h0000_5000});
      win_rd(base + 8'h1, rd, er);
      check("R5 hi full", {32'h0, rd}, {32'h0, hi});
      @(negedge clk); irq_in[n] = 1'b1;
      @(negedge clk); irq_in[n] = 1'b0;
      check("R7 R12 valid", {63'h0, msg_valid}, {63'h0, ~lo[16]});
      if (!lo[16]) begin
        check("R8 word", msg_word, exp_msg(lo, hi));
        check("R8 src", {60'h0, msg_src}, 64'hA);
      end
      @(negedge clk);
      check("R7 single", {63'h0, msg_valid}, 64'h0);
    end
    // R10 simultaneous
    win_wr(8'h16, 32'h0000_0033, er); win_wr(8'h17, 32'h0300_0000, er);
    win_wr(8'h1A, 32'h0000_8155, er); win_wr(8'h1B, 32'h0500_0000, er);
    win_wr(8'h22, 32'h0000_0899, er); win_wr(8'h23, 32'h0900_0000, er);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[5] = 1'b1; irq_in[9] = 1'b1;
    @(negedge clk); irq_in = '0;
    check("R10 first", msg_word, exp_msg(32'h33, 32'h0300_0000));
    @(negedge clk);
    check("R10 second", msg_word, exp_msg(32'h8155, 32'h0500_0000));
    @(negedge clk);
    check("R10 third", {63'h0, msg_valid} | (msg_word << 1), {exp_msg(32'h899, 32'h0900_0000), 1'b1});
    @(negedge clk);
    check("R10 drained", {63'h0, msg_valid}, 64'h0);
    // R11 back-pressure
    win_wr(8'h1E, 32'h0000_0277, er); win_wr(8'h1F, 32'h7700_0000, er);
    msg_ready = 1'b0;
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk); irq_in[7] = 1'b0;
    held = exp_msg(32'h277, 32'h7700_0000);
    check("R11 offered", msg_word, held);
    repeat (3) @(negedge clk);
    check("R11 valid held", {63'h0, msg_valid}, 64'h1);
    check("R11 word held", msg_word, held);
    msg_ready = 1'b1;
    @(negedge clk);
    check("R11 released", {63'h0, msg_valid}, 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule